// File: doc/BRIEF.md
# Interrupt Condition Router

This block steers ninety-six level-sensitive interrupt conditions onto eight interrupt destination lines. The conditions form six groups of sixteen: doorbell groups 0 to 3, then a receive group, then a transmit group. Every condition has its own 4-bit routing code. A code in the range 0 to 7 picks a destination. The code 1111b, and every reserved code, keeps the condition off all destinations.

Each destination line is the OR of all asserted conditions routed to it. Software reads and writes the routing codes through a simple word-wide register port. Eight codes are packed into each 32-bit word, and each group uses two words. The block only routes and stores the configuration. Producing the condition levels, clearing them and pacing interrupts are handled elsewhere.

Top module: `irq_route_bank`

## Requirements
- R1: A routing code of value n, with n from 0 to 7, drives condition input s onto destination n.
- R2: Routing code 1111b keeps its condition off every destination.
- R3: Codes 1000b to 1110b are reserved. A condition carrying one drives no destination, and the stored code reads back unchanged.
- R4: After reset every routing word reads zero and every condition is routed to destination 0.
- R5: Within a group, the word at the group base holds conditions 0 to 7 and the word at base+4 holds conditions 8 to 15. Condition k of a word sits in bits 4k+3 to 4k.
- R6: Group g, for g from 0 to 5, has its base at byte offset 0x280 + 0x10*g. Its condition c is input bit cond_in[16*g + c].
- R7: dest_irq[n] is the OR of every asserted cond_in bit whose code is n. It follows cond_in within the same cycle.
- R8: A write changes routing from the clock edge that captures it. Reads return the stored word combinationally.
- R9: Reads of any offset outside the twelve routing words return zero. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 12 | Byte offset of the routing word |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| cond_in | input | 96 | Condition levels, group-major |
| dest_irq | output | 8 | Destination interrupt lines |

## Verification
The hardest case to reach from the ports is proving that a single field decodes in isolation: that a reserved code or a mis-placed nibble does not leak onto some destination while other conditions mask it. Before each vector the stimulus disables every condition by writing all-ones to all twelve words. It then writes one nibble and raises exactly one condition bit, so any destination that lights up can only come from that field. Aliasing writes to the unused third and fourth words of a group slot are caught by reading every word back afterwards.

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NGRP = 6,
  parameter int NCOND = 16,
  parameter int NDEST = 8,
  parameter int FW = 4,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h280
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         cfg_addr,
  input  logic                  cfg_we,
  input  logic [DW-1:0]         cfg_wdata,
  output logic [DW-1:0]         cfg_rdata,
  input  logic [NGRP*NCOND-1:0] cond_in,
  output logic [NDEST-1:0]      dest_irq
);
  localparam int FPW = DW / FW;
  localparam int WPG = NCOND / FPW;
  localparam int NWORD = NGRP * WPG;
  localparam int NSRC = NGRP * NCOND;
  localparam int IW = $clog2(NWORD);

  logic [DW-1:0] word_q [NWORD];
  logic [AW-1:0] off;
  logic [IW-1:0] widx;
  logic          hit;
  logic [FW-1:0] code [NSRC];

  assign off  = cfg_addr - BASE;
  assign hit  = (cfg_addr >= BASE) && (32'(off[AW-1:4]) < NGRP) && (32'(off[3:2]) < WPG);
  assign widx = IW'(32'(off[AW-1:4]) * WPG + 32'(off[3:2]));
  assign cfg_rdata = hit ? word_q[widx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORD; w++) word_q[w] <= '0;
    end else if (cfg_we && hit) begin
      word_q[widx] <= cfg_wdata;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_code
    assign code[s] = word_q[s / FPW][(s % FPW) * FW +: FW];
  end

  always_comb begin
    dest_irq = '0;
    for (int d = 0; d < NDEST; d++)
      for (int s = 0; s < NSRC; s++)
        if (cond_in[s] && code[s] == FW'(d)) dest_irq[d] = 1'b1;
  end
endmodule

// File: rtl/irq_route_bank_chk.sv
module irq_route_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] cfg_addr,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [95:0] cond_in,
  input logic [7:0]  dest_irq
);
  logic in_win;
  assign in_win = (cfg_addr[11:4] >= 8'h28) && (cfg_addr[11:4] <= 8'h2D) && !cfg_addr[3];

  a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> cfg_rdata == 32'h0);

  a_r7_idle_conditions_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cond_in == '0 |-> dest_irq == '0);

  a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_win) |=> ($stable(cfg_addr) -> cfg_rdata == $past(cfg_wdata)));

  a_r7_output_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(cond_in)) |-> $stable(dest_irq));
endmodule

bind irq_route_bank irq_route_bank_chk u_chk (.*);

// File: tb/irq_route_bank_test.sv
module irq_route_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] cfg_addr = '0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [95:0] cond_in = '0;
  logic [7:0]  dest_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_route_bank uut (.*);

  // {group, condition, code, expected destination mask}
  localparam logic [19:0] VEC [12] = '{
    {4'd0, 4'd0,  4'h0, 8'h01}, {4'd0, 4'd7,  4'h5, 8'h20},
    {4'd1, 4'd8,  4'h7, 8'h80}, {4'd1, 4'd15, 4'h2, 8'h04},
    {4'd2, 4'd3,  4'hF, 8'h00}, {4'd2, 4'd12, 4'h6, 8'h40},
    {4'd3, 4'd1,  4'h9, 8'h00}, {4'd3, 4'd9,  4'h4, 8'h10},
    {4'd4, 4'd5,  4'h1, 8'h02}, {4'd4, 4'd14, 4'hE, 8'h00},
    {4'd5, 4'd0,  4'h3, 8'h08}, {4'd5, 4'd15, 4'h8, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [11:0] waddr(input int w);
    return 12'(12'h280 + (w / 2) * 16 + (w % 2) * 4);
  endfunction

  task automatic disable_all();
    for (int w = 0; w < 12; w++) wr(waddr(w), 32'hFFFF_FFFF);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4: reset state
    for (int w = 0; w < 12; w++) begin
      rd(waddr(w), r);
      chk("R4 reset word", r, 32'h0);
    end
    cond_in = '1; #1;
    chk("R4 all to dest0", {24'h0, dest_irq}, 32'h01);
    cond_in = '0;

    // R1 R2 R3 R5 R6: one field at a time
    for (int v = 0; v < 12; v++) begin
      int g, c, cd;
      logic [31:0] d;
      g = int'(VEC[v][19:16]); c = int'(VEC[v][15:12]); cd = int'(VEC[v][11:8]);
      cond_in = '0;
      disable_all();
      d = 32'hFFFF_FFFF;
      d[(c % 8) * 4 +: 4] = 4'(cd);
      wr(12'(12'h280 + g * 16 + (c / 8) * 4), d);
      cond_in[g * 16 + c] = 1'b1;
      #1 chk("R1 R2 R3 R5 R6 vector", {24'h0, dest_irq}, {24'h0, VEC[v][7:0]});
    end

    // R7: OR of two sources into one destination
    cond_in = '0;
    disable_all();
    wr(12'h280, 32'hFFFF_F3FF);
    wr(12'h2D4, 32'hFFFF_F3FF);
    cond_in[2] = 1; #1;
    chk("R7 first source", {24'h0, dest_irq}, 32'h08);
    cond_in[2] = 0; cond_in[90] = 1; #1;
    chk("R7 second source", {24'h0, dest_irq}, 32'h08);
    cond_in = '1; #1;
    chk("R7 both plus disabled", {24'h0, dest_irq}, 32'h08);
    cond_in = '0; #1;
    chk("R7 none", {24'h0, dest_irq}, 32'h0);

    // R8: routing changes from the capturing edge
    disable_all();
    cond_in = '0; cond_in[0] = 1;
    @(negedge clk);
    cfg_addr = 12'h280; cfg_wdata = 32'hFFFF_FFF6; cfg_we = 1;
    #1 chk("R8 before edge", {24'h0, dest_irq}, 32'h0);
    @(negedge clk);
    cfg_we = 0;
    chk("R8 after edge", {24'h0, dest_irq}, 32'h40);
    rd(12'h280, r);
    chk("R8 readback", r, 32'hFFFF_FFF6);

    // R3: reserved codes stored and silent
    disable_all();
    wr(12'h2C4, 32'h89AB_CDEF);
    rd(12'h2C4, r);
    chk("R3 reserved readback", r, 32'h89AB_CDEF);
    cond_in = '0; cond_in[79:72] = 8'hFF; #1;
    chk("R3 reserved silent", {24'h0, dest_irq}, 32'h0);

    // R9: outside offsets
    cond_in = '0;
    disable_all();
    wr(12'h288, 32'h0);
    wr(12'h28C, 32'h0);
    wr(12'h27C, 32'h0);
    wr(12'h2E0, 32'h0);
    rd(12'h288, r); chk("R9 read 288", r, 32'h0);
    rd(12'h27C, r); chk("R9 read 27C", r, 32'h0);
    rd(12'h2E0, r); chk("R9 read 2E0", r, 32'h0);
    for (int w = 0; w < 12; w++) begin
      rd(waddr(w), r);
      chk("R9 writes ignored", r, 32'hFFFF_FFFF);
    end
    cond_in = '1; #1;
    chk("R9 routing untouched", {24'h0, dest_irq}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule